// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the multiplexed address/data pins of a burst-capable flash device and turns the host's bus write cycles into configuration and mode changes. It samples the chip-select, address-valid and write strobes on the system clock. It latches a 22-bit address when the address-valid strobe is released and captures a 16-bit data word when the write strobe is released. Each captured write is then matched against the expected command sequences.

Three results come out of the decoding. The first is the burst configuration register, which holds a burst ordering and an initial-latency code. The second is a sticky power-save enable flag. The third is the current read mode, which is either array reads or the identification query table. The configuration payload travels in address bits of the final write, not in the data word. Any write that breaks a sequence drops the decoder back to array reads and leaves the register untouched. Program, erase, status polling, protection and the storage array are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset the outputs are `burst_mode`=00 (continuous), `wait_code`=5 (seven initial cycles), `ps_enable`=0, `cfi_mode`=0 and `config_updated`=0.
- R2: An address `{a_hi, adq_in}` is latched on the clock where a rising `avd_n` is first seen with `ce_n` low. A write is taken on the clock where a rising `we_n` is first seen with `ce_n` low. Strobes toggled while `ce_n` is high have no effect on any output or on the sequence in progress.
- R3: When `inv_in` is high as the write strobe rises, the captured data word is the bitwise complement of `adq_in`.
- R4: The writes AAh at offset 555h, then 55h at offset 2AAh, then C0h at offset 555h load the register. The burst mode is taken from address bits 16..15 (00 continuous, 01 8-word wrap, 10 16-word wrap, 11 32-word wrap) and the wait code from bits 14..12. Offsets compare address bits 11..0 only. Commands compare data bits 7..0 only. Address bits 21..17 are ignored.
- R5: A configuration write whose wait code is 6 or 7 aborts the sequence and leaves the register unchanged.
- R6: A register load becomes visible on the second clock edge after the write strobe rises. `config_updated` is high for exactly that one cycle, and only for loads. Without a load the register holds its value.
- R7: A write that does not match the expected step of an unfinished sequence abandons it. Later steps then count only after a fresh AAh/555h.
- R8: Writing 98h at offset 055h, with no sequence open, sets `cfi_mode`. F0h at any address clears it. So does any unrecognised write, and so does the completion of any three-write command.
- R9: The writes AAh/555h, 55h/2AAh, 70h/555h set `ps_enable`. Only reset clears it.
- R10: F0h at any address, at any step, closes an open sequence without changing the register or the power-save flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| avd_n | input | 1 | Address valid strobe, address latched on release |
| we_n | input | 1 | Write strobe, data captured on release |
| inv_in | input | 1 | High when the data on the bus is sent inverted |
| adq_in | input | 16 | Multiplexed low address / data bus |
| a_hi | input | 6 | Address-only upper bits 21..16 |
| burst_mode | output | 2 | Burst ordering: 00 continuous, 01/10/11 wrap of 8/16/32 |
| wait_code | output | 3 | Initial latency code, 0..5 meaning 2..7 clocks |
| ps_enable | output | 1 | Sticky power-save enable |
| cfi_mode | output | 1 | High while the query table is selected instead of the array |
| config_updated | output | 1 | One-cycle pulse when the register is loaded |

## Verification
On every cycle the assertions check three properties of the register: the wait code never leaves the legal range, the register stays stable unless the update pulse is high, and the pulse never lasts two cycles. They also check that the power-save flag never falls outside reset, that one strobe yields one captured write, and that the sequence tracker returns to idle after a final step or an abort. Only the bench scenarios can show that the right field bits reach the register and that an inverted bus decodes correctly. They also cover interrupted or deselected sequences, which must leave the configuration alone, and the query mode entry and exit. Each of these is compared against a reference model of the command rules over directed and seeded random write streams.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int OFS_W    = 12;
    localparam int CMD_W    = 8;
    localparam int MODE_LSB = 15;
    localparam int WAIT_LSB = 12;

    localparam logic [CMD_W-1:0] CMD_KEY_A   = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_KEY_B   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SET_CFG = 8'hC0;
    localparam logic [CMD_W-1:0] CMD_PS_ON   = 8'h70;
    localparam logic [CMD_W-1:0] CMD_QUERY   = 8'h98;
    localparam logic [CMD_W-1:0] CMD_RESET   = 8'hF0;

    localparam logic [OFS_W-1:0] OFS_KEY_A = 12'h555;
    localparam logic [OFS_W-1:0] OFS_KEY_B = 12'h2AA;
    localparam logic [OFS_W-1:0] OFS_QUERY = 12'h055;

    localparam logic [2:0] WAIT_MAX     = 3'd5;
    localparam logic [2:0] WAIT_DEFAULT = 3'd5;

    typedef enum logic [1:0] {
        BM_CONT   = 2'b00,
        BM_WRAP8  = 2'b01,
        BM_WRAP16 = 2'b10,
        BM_WRAP32 = 2'b11
    } burst_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_KEY1 = 2'd1,
        SQ_KEY2 = 2'd2
    } seq_e;

    typedef enum logic {
        RM_ARRAY = 1'b0,
        RM_QUERY = 1'b1
    } rmode_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RESET   = 3'd1,
        OP_ABORT   = 3'd2,
        OP_ADVANCE = 3'd3,
        OP_QUERY   = 3'd4,
        OP_SET_CFG = 3'd5,
        OP_PS_ON   = 3'd6
    } op_e;

    typedef struct packed {
        burst_e     mode;
        logic [2:0] wcode;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_DEFAULT = '{mode: BM_CONT, wcode: WAIT_DEFAULT};

    function automatic logic step_hit(
        input logic [OFS_W-1:0] ofs, input logic [CMD_W-1:0] cmd,
        input logic [OFS_W-1:0] want_ofs, input logic [CMD_W-1:0] want_cmd);
        return (ofs == want_ofs) && (cmd == want_cmd);
    endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              avd_n,
    input  logic              we_n,
    input  logic              inv_in,
    input  logic [DATA_W-1:0] adq_in,
    input  logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic avd_q;
    logic we_q;
    logic avd_rise;
    logic we_rise;

    assign avd_rise = !avd_q && avd_n && !ce_n;
    assign we_rise  = !we_q && we_n && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            avd_q <= 1'b1;
            we_q  <= 1'b1;
            stb   <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else begin
            avd_q <= avd_n;
            we_q  <= we_n;
            stb   <= we_rise;
            if (avd_rise) begin
                addr <= {a_hi, adq_in};
            end
            if (we_rise) begin
                data <= adq_in ^ {DATA_W{inv_in}};
            end
        end
    end

    // R2: one strobe release produces a single captured write
    p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb)
        else $error("captured write strobe lasted two cycles");

endmodule

// File: rtl/fcd_seq_decoder.sv
module fcd_seq_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output op_e               op,
    output burst_cfg_t        cand
);
    localparam int HI_LSB = MODE_LSB + 2;

    seq_e             state;
    seq_e             state_nxt;
    logic [OFS_W-1:0] ofs;
    logic [CMD_W-1:0] cmd;
    logic [2:0]       wfield;
    logic             unused_bits;

    assign ofs         = addr[OFS_W-1:0];
    assign cmd         = data[CMD_W-1:0];
    assign wfield      = addr[WAIT_LSB +: 3];
    assign unused_bits = ^{addr[ADDR_W-1:HI_LSB], data[DATA_W-1:CMD_W]};

    assign cand.mode  = burst_e'(addr[MODE_LSB +: 2]);
    assign cand.wcode = wfield;

    always_comb begin
        op        = OP_NONE;
        state_nxt = state;
        if (stb) begin
            if (cmd == CMD_RESET) begin
                op        = OP_RESET;
                state_nxt = SQ_IDLE;
            end else begin
                unique case (state)
                    SQ_IDLE: begin
                        if (step_hit(ofs, cmd, OFS_KEY_A, CMD_KEY_A)) begin
                            op        = OP_ADVANCE;
                            state_nxt = SQ_KEY1;
                        end else if (step_hit(ofs, cmd, OFS_QUERY, CMD_QUERY)) begin
                            op = OP_QUERY;
                        end else begin
                            op = OP_ABORT;
                        end
                    end
                    SQ_KEY1: begin
                        if (step_hit(ofs, cmd, OFS_KEY_B, CMD_KEY_B)) begin
                            op        = OP_ADVANCE;
                            state_nxt = SQ_KEY2;
                        end else begin
                            op        = OP_ABORT;
                            state_nxt = SQ_IDLE;
                        end
                    end
                    SQ_KEY2: begin
                        state_nxt = SQ_IDLE;
                        if (step_hit(ofs, cmd, OFS_KEY_A, CMD_SET_CFG) && (wfield <= WAIT_MAX)) begin
                            op = OP_SET_CFG;
                        end else if (step_hit(ofs, cmd, OFS_KEY_A, CMD_PS_ON)) begin
                            op = OP_PS_ON;
                        end else begin
                            op = OP_ABORT;
                        end
                    end
                    default: begin
                        op        = OP_ABORT;
                        state_nxt = SQ_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // R7: the last step of a sequence always closes it
    p_key2_exits_r7: assert property (@(posedge clk) disable iff (rst)
        (stb && state == SQ_KEY2) |=> (state == SQ_IDLE))
        else $error("sequence stayed open after its final write");

    // R7: an abandoned sequence restarts from idle
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ABORT) |=> (state == SQ_IDLE))
        else $error("sequence not reset after a mismatched write");

    // R10: the reset command never leaves a sequence open
    p_reset_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RESET) |=> (state == SQ_IDLE))
        else $error("reset command left a sequence open");

endmodule

// File: rtl/fcd_cfg_store.sv
module fcd_cfg_store
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_e        op,
    input  burst_cfg_t cand,
    output burst_cfg_t cfg,
    output logic       ps_on,
    output rmode_e     rmode,
    output logic       updated
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= CFG_DEFAULT;
            ps_on   <= 1'b0;
            rmode   <= RM_ARRAY;
            updated <= 1'b0;
        end else begin
            updated <= 1'b0;
            unique case (op)
                OP_SET_CFG: begin
                    cfg     <= cand;
                    updated <= 1'b1;
                    rmode   <= RM_ARRAY;
                end
                OP_PS_ON: begin
                    ps_on <= 1'b1;
                    rmode <= RM_ARRAY;
                end
                OP_QUERY: rmode <= RM_QUERY;
                OP_RESET,
                OP_ABORT: rmode <= RM_ARRAY;
                default: ;
            endcase
        end
    end

    // R5: the stored wait code is always a legal one
    p_wait_legal_r5: assert property (@(posedge clk) disable iff (rst)
        cfg.wcode <= WAIT_MAX)
        else $error("illegal wait code stored");

    // R6: register holds its value except on the update pulse
    p_cfg_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !updated |-> $stable(cfg))
        else $error("configuration changed without an update pulse");

    // R6: the update pulse is a single cycle
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (rst)
        updated |=> !updated)
        else $error("update pulse longer than one cycle");

    // R9: power-save flag is sticky outside reset
    p_ps_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ps_on) |-> ps_on)
        else $error("power-save flag dropped without reset");

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce_n,
    input  logic                     avd_n,
    input  logic                     we_n,
    input  logic                     inv_in,
    input  logic [DATA_W-1:0]        adq_in,
    input  logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [1:0]               burst_mode,
    output logic [2:0]               wait_code,
    output logic                     ps_enable,
    output logic                     cfi_mode,
    output logic                     config_updated
);
    logic              stb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    op_e               op;
    burst_cfg_t        cand;
    burst_cfg_t        cfg;
    rmode_e            rmode;

    fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .avd_n  (avd_n),
        .we_n   (we_n),
        .inv_in (inv_in),
        .adq_in (adq_in),
        .a_hi   (a_hi),
        .stb    (stb),
        .addr   (addr),
        .data   (data)
    );

    fcd_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .addr (addr),
        .data (data),
        .op   (op),
        .cand (cand)
    );

    fcd_cfg_store u_cfg (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .cand    (cand),
        .cfg     (cfg),
        .ps_on   (ps_enable),
        .rmode   (rmode),
        .updated (config_updated)
    );

    assign burst_mode = cfg.mode;
    assign wait_code  = cfg.wcode;
    assign cfi_mode   = (rmode == RM_QUERY);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        avd_n = 1'b1;
    logic        we_n = 1'b1;
    logic        inv_in = 1'b0;
    logic [15:0] adq_in = '0;
    logic [5:0]  a_hi = '0;
    logic [1:0]  burst_mode;
    logic [2:0]  wait_code;
    logic        ps_enable;
    logic        cfi_mode;
    logic        config_updated;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int         m_seq;
    logic       m_cfi;
    logic [1:0] m_bm;
    logic [2:0] m_wc;
    logic       m_ps;
    logic       m_upd;

    always #4 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .avd_n(avd_n), .we_n(we_n),
        .inv_in(inv_in), .adq_in(adq_in), .a_hi(a_hi),
        .burst_mode(burst_mode), .wait_code(wait_code), .ps_enable(ps_enable),
        .cfi_mode(cfi_mode), .config_updated(config_updated)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_seq = 0; m_cfi = 1'b0; m_bm = 2'b00; m_wc = 3'd5; m_ps = 1'b0; m_upd = 1'b0;
    endtask

    task automatic model_apply(input logic [21:0] a, input logic [15:0] d);
        logic [11:0] o;
        logic [7:0]  c;
        o = a[11:0];
        c = d[7:0];
        m_upd = 1'b0;
        if (c == 8'hF0) begin
            m_seq = 0; m_cfi = 1'b0;
        end else if (m_seq == 0) begin
            if (c == 8'hAA && o == 12'h555) m_seq = 1;
            else if (c == 8'h98 && o == 12'h055) m_cfi = 1'b1;
            else m_cfi = 1'b0;
        end else if (m_seq == 1) begin
            if (c == 8'h55 && o == 12'h2AA) m_seq = 2;
            else begin m_seq = 0; m_cfi = 1'b0; end
        end else begin
            m_seq = 0; m_cfi = 1'b0;
            if (o == 12'h555 && c == 8'hC0 && a[14:12] <= 3'd5) begin
                m_bm = a[16:15]; m_wc = a[14:12]; m_upd = 1'b1;
            end else if (o == 12'h555 && c == 8'h70) begin
                m_ps = 1'b1;
            end
        end
    endtask

    task automatic check_state(input string req);
        chk(burst_mode == m_bm, req, "burst_mode", burst_mode, m_bm);
        chk(wait_code == m_wc, req, "wait_code", wait_code, m_wc);
        chk(ps_enable == m_ps, req, "ps_enable", ps_enable, m_ps);
        chk(cfi_mode == m_cfi, req, "cfi_mode", cfi_mode, m_cfi);
        chk(config_updated == m_upd, req, "config_updated", config_updated, m_upd);
    endtask

    // bus cycle; d is the word the decoder should see after any inversion
    task automatic bus_write(input logic [21:0] a, input logic [15:0] d,
                             input logic inv, input logic sel);
        ce_n = !sel; avd_n = 1'b0; adq_in = a[15:0]; a_hi = a[21:16];
        @(negedge clk);
        avd_n = 1'b1;
        @(negedge clk);
        adq_in = inv ? ~d : d; inv_in = inv; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        inv_in = 1'b0; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [21:0] a, input logic [15:0] d,
                      input logic inv, input string req);
        bus_write(a, d, inv, 1'b1);
        model_apply(a, d);
        check_state(req);
        if (m_upd) begin
            @(negedge clk);
            chk(config_updated == 1'b0, "R6", "pulse width", config_updated, 0);
        end
    endtask

    function automatic logic [21:0] cfg_addr(input logic [4:0] junk,
                                             input logic [1:0] m, input logic [2:0] w);
        return {junk, m, w, 12'h555};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        check_state("R1");

        // R4 / R6: a full load with junk in the ignored upper bits
        wr(22'h000555, 16'h00AA, 1'b0, "R4");
        wr(22'h0002AA, 16'h0055, 1'b0, "R4");
        wr(cfg_addr(5'b10101, 2'b10, 3'd2), 16'h00C0, 1'b0, "R4");
        chk(burst_mode == 2'b10, "R4", "mode field", burst_mode, 2);

        // R5: wait code 6 and 7 rejected
        wr(22'h000555, 16'h00AA, 1'b0, "R5");
        wr(22'h0002AA, 16'h0055, 1'b0, "R5");
        wr(cfg_addr(5'd0, 2'b01, 3'd6), 16'h00C0, 1'b0, "R5");
        wr(22'h000555, 16'h00AA, 1'b0, "R5");
        wr(22'h0002AA, 16'h0055, 1'b0, "R5");
        wr(cfg_addr(5'd3, 2'b11, 3'd7), 16'h00C0, 1'b0, "R5");

        // R7: broken second step, then lone third step does nothing
        wr(22'h000555, 16'h00AA, 1'b0, "R7");
        wr(22'h0002AA, 16'h0012, 1'b0, "R7");
        wr(cfg_addr(5'd0, 2'b11, 3'd0), 16'h00C0, 1'b0, "R7");

        // R8: query entry and exits
        wr(22'h000055, 16'h0098, 1'b0, "R8");
        wr(22'h000100, 16'h1234, 1'b0, "R8");
        wr(22'h000055, 16'h0098, 1'b0, "R8");
        wr(22'h3FFFFF, 16'h00F0, 1'b0, "R8");

        // R10: reset command inside a sequence
        wr(22'h000555, 16'h00AA, 1'b0, "R10");
        wr(22'h0002AA, 16'h0055, 1'b0, "R10");
        wr(22'h000555, 16'h00F0, 1'b0, "R10");
        wr(cfg_addr(5'd0, 2'b01, 3'd1), 16'h00C0, 1'b0, "R10");

        // R9: power-save sticky across commands, cleared by reset
        wr(22'h000555, 16'h00AA, 1'b0, "R9");
        wr(22'h0002AA, 16'h0055, 1'b0, "R9");
        wr(22'h000555, 16'h0070, 1'b0, "R9");
        wr(22'h000000, 16'h00F0, 1'b0, "R9");
        wr(22'h000777, 16'hBEEF, 1'b0, "R9");
        chk(ps_enable == 1'b1, "R9", "sticky flag", ps_enable, 1);
        do_reset();
        check_state("R1");
        chk(ps_enable == 1'b0, "R9", "cleared by reset", ps_enable, 0);

        // R3: every step sent inverted
        wr(22'h000555, 16'h00AA, 1'b1, "R3");
        wr(22'h0002AA, 16'h0055, 1'b1, "R3");
        wr(cfg_addr(5'd9, 2'b01, 3'd3), 16'h00C0, 1'b1, "R3");

        // R2: a deselected write in the middle is ignored
        wr(22'h000555, 16'h00AA, 1'b0, "R2");
        wr(22'h0002AA, 16'h0055, 1'b0, "R2");
        bus_write(22'h000000, 16'h00F0, 1'b0, 1'b0);
        check_state("R2");
        bus_write(cfg_addr(5'd0, 2'b11, 3'd4), 16'h00C0, 1'b0, 1'b0);
        check_state("R2");
        wr(cfg_addr(5'd0, 2'b00, 3'd0), 16'h00C0, 1'b0, "R2");

        // seeded random command streams
        for (int t = 0; t < 120; t++) begin
            int          kind;
            logic        inv;
            logic [21:0] ra;
            logic [15:0] rd;
            int          bad;
            kind = $urandom_range(0, 5);
            inv  = 1'($urandom_range(0, 1));
            bad  = $urandom_range(0, 2);
            ra   = cfg_addr(5'($urandom), 2'($urandom), 3'($urandom_range(0, 7)));
            case (kind)
                0: begin
                    wr(22'h000555, 16'h00AA, inv, "R4");
                    wr({10'($urandom), 12'h2AA}, 16'h0055, inv, "R4");
                    wr(ra, {8'($urandom), 8'hC0}, inv, "R4");
                end
                1: begin
                    wr(22'h000555, 16'h00AA, inv, "R9");
                    wr(22'h0002AA, 16'h0055, inv, "R9");
                    wr(22'h000555, 16'h0070, inv, "R9");
                end
                2: wr({10'($urandom), 12'h055}, 16'h0098, inv, "R8");
                3: wr(22'($urandom), {8'($urandom), 8'hF0}, inv, "R10");
                4: wr(22'($urandom), 16'($urandom), inv, "R7");
                default: begin
                    wr(22'h000555, (bad == 0) ? 16'h00AB : 16'h00AA, inv, "R7");
                    wr(22'h0002AA, (bad == 1) ? 16'h0054 : 16'h0055, inv, "R7");
                    wr(ra, (bad == 2) ? 16'h00C1 : 16'h00C0, inv, "R7");
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule